// File: doc/BRIEF.md
# Dithered High-Resolution PWM Generator

This block produces a one-bit pulse-width waveform whose average level resolves finer steps than its frame counter alone allows. A setpoint of CNT_W + FRAC_W bits is split in two. The upper CNT_W bits (the base code) set the high time of an ordinary frame that is 2^CNT_W clocks long. The lower FRAC_W bits (the fraction) feed a first-order delta-sigma accumulator. This accumulator steps once per frame and decides whether the next frame uses the base code or the base code plus one.

Every frame therefore sits on one of two neighbouring duty levels. The mix of the two levels carries the fractional part, and an external low-pass filter turns it into a finely resolved analog level. The waveform has at most one rising and one falling edge per frame, whatever the code. This keeps the edge count per period constant, so edge-slew errors do not depend on the code. A frame-start strobe marks each frame boundary. The setpoint is sampled only at those boundaries, so it may be changed at any time.

Top module: `dpwm_dither_gen`

## Requirements
- R1: The frame counter runs through 2^CNT_W clocks per frame and wraps to zero. CNT_W must lie between 12 and 16 and FRAC_W must be at least 1, or elaboration stops with an error.
- R2: `frame_start` is high for exactly one clock, the clock in which the frame counter is zero. It therefore pulses once every 2^CNT_W clocks, including the first clock after reset.
- R3: `setpoint` is sampled only on the last clock of a frame. A change made in mid-frame has no effect on the current frame and applies from the next frame start.
- R4: On each frame boundary, the fraction `setpoint[FRAC_W-1:0]` is added to an FRAC_W-bit accumulator. The carry out of that addition selects the next frame's compare value, which is the base code `setpoint[CNT_W+FRAC_W-1:FRAC_W]` plus the carry (0 or 1).
- R5: `pwm_out` is high exactly while the frame counter is below the current compare value.
- R6: A compare value of zero gives an output that is low for the whole frame. A full-scale base code plus a carry gives a compare value of 2^CNT_W, so the output is high for the whole frame; it never wraps to zero.
- R7: Within a frame, `pwm_out` rises at most once, and only in the clock where the counter is zero. It falls at most once, and only in the clock where the counter equals the compare value.
- R8: Over any 2^FRAC_W consecutive frames with a constant setpoint, the number of clocks with `pwm_out` high equals the full setpoint value read as an unsigned integer.
- R9: A synchronous reset clears the counter, the accumulator and the compare value. The first frame after reset is therefore entirely low, whatever the setpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous reset, active high |
| setpoint | input | CNT_W+FRAC_W | Base code (upper CNT_W bits) and fraction (lower FRAC_W bits), sampled at frame boundaries |
| pwm_out | output | 1 | Dithered PWM waveform |
| frame_start | output | 1 | One-clock strobe in the first clock of each frame |

## Verification
A wrong accumulator value or a lost carry moves the falling edge of a frame by exactly one clock. It shows at the ports within the first affected frame, and it makes the total over a 2^FRAC_W-frame window differ from the setpoint. A compare value loaded at the wrong time shows up in the current frame as a falling edge at a position that the old setpoint would not produce. A counter that wraps wrongly shifts `frame_start` away from its 2^CNT_W spacing within one frame. A compare value that wraps at full scale turns a frame that should be fully high into a fully low one. Because the reference is compared on every clock, each of these faults is caught in the clock where it first appears.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
   // Legal range of the frame counter width.
   localparam int unsigned DPWM_MIN_CNT_W = 12;
   localparam int unsigned DPWM_MAX_CNT_W = 16;
   // Smallest accepted fraction width.
   localparam int unsigned DPWM_MIN_FRAC_W = 1;
endpackage

// File: rtl/dpwm_frame_timer.sv
module dpwm_frame_timer #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt,
   output logic             last,
   output logic             start
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   assign cnt   = cnt_q;
   assign last  = (cnt_q == {CNT_W{1'b1}});
   assign start = (cnt_q == '0);

   // R1: the frame wraps right after its last clock
   a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
      last |=> (cnt_q == '0));
endmodule

// File: rtl/dpwm_dither_acc.sv
module dpwm_dither_acc #(
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned FRAC_W = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    load,
   input  logic [CNT_W+FRAC_W-1:0] setpoint,
   output logic [CNT_W:0]          cmp
);
   localparam logic [CNT_W:0] FULL_CMP = {1'b1, {CNT_W{1'b0}}};

   logic [CNT_W-1:0]  base;
   logic [FRAC_W-1:0] frac;
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;
   logic              carry;
   logic [CNT_W:0]    next_cmp;
   logic [CNT_W:0]    cmp_q;

   assign base  = setpoint[CNT_W+FRAC_W-1:FRAC_W];
   assign frac  = setpoint[FRAC_W-1:0];
   assign sum   = {1'b0, acc_q} + {1'b0, frac};
   assign carry = sum[FRAC_W];

   // One extra bit of range: base 2^CNT_W-1 plus a carry lands on 2^CNT_W.
   // The clamp only keeps the value in range if the width is ever narrowed.
   always_comb begin
      next_cmp = {1'b0, base} + {{CNT_W{1'b0}}, carry};
      if (next_cmp > FULL_CMP) next_cmp = FULL_CMP;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         cmp_q <= '0;
      end else if (load) begin
         acc_q <= sum[FRAC_W-1:0];
         cmp_q <= next_cmp;
      end
   end

   assign cmp = cmp_q;

   // R3: between boundaries the compare value holds
   a_r3_hold_midframe: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(cmp_q));
   // R4: a newly loaded compare value is the sampled base code or one above it
   a_r4_base_or_next: assert property (@(posedge clk) disable iff (rst)
      load |=> ((cmp_q >= {1'b0, $past(base)}) &&
                (cmp_q <= {1'b0, $past(base)} + 1'b1)));
   // R6: the compare value never leaves the range 0 to 2^CNT_W
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
      cmp_q <= FULL_CMP);
endmodule

// File: rtl/dpwm_compare.sv
module dpwm_compare #(
   parameter int unsigned CNT_W = 12
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W:0]   cmp,
   output logic             pwm
);
   assign pwm = ({1'b0, cnt} < cmp);
endmodule

// File: rtl/dpwm_dither_gen.sv
module dpwm_dither_gen #(
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned FRAC_W = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [CNT_W+FRAC_W-1:0] setpoint,
   output logic                    pwm_out,
   output logic                    frame_start
);
   import dpwm_pkg::*;

   localparam logic [CNT_W:0] FULL_CMP = {1'b1, {CNT_W{1'b0}}};

   generate
      if ((CNT_W < DPWM_MIN_CNT_W) || (CNT_W > DPWM_MAX_CNT_W)) begin : g_bad_cnt
         $error("dpwm_dither_gen: CNT_W out of range");
      end
      if (FRAC_W < DPWM_MIN_FRAC_W) begin : g_bad_frac
         $error("dpwm_dither_gen: FRAC_W too small");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             last;
   logic             start;
   logic [CNT_W:0]   cmp;
   logic             pwm;

   dpwm_frame_timer #(.CNT_W(CNT_W)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .cnt  (cnt),
      .last (last),
      .start(start)
   );

   dpwm_dither_acc #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .load    (last),
      .setpoint(setpoint),
      .cmp     (cmp)
   );

   dpwm_compare #(.CNT_W(CNT_W)) u_cmp (
      .cnt(cnt),
      .cmp(cmp),
      .pwm(pwm)
   );

   assign pwm_out     = pwm;
   assign frame_start = start;

   // R2: the strobe lasts a single clock
   a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> !frame_start);
   // R6: an empty compare gives low, a full-scale compare gives high
   a_r6_zero_low: assert property (@(posedge clk) disable iff (rst)
      (cmp == '0) |-> !pwm_out);
   a_r6_full_high: assert property (@(posedge clk) disable iff (rst)
      (cmp == FULL_CMP) |-> pwm_out);
   // R7: rising edges only at frame start, falling edges only at the compare point
   a_r7_rise_at_start: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out) |-> frame_start);
   a_r7_fall_at_cmp: assert property (@(posedge clk) disable iff (rst)
      $fell(pwm_out) |-> ({1'b0, cnt} == cmp));
endmodule

// File: tb/sim_dpwm_dither_gen.sv
`timescale 1ns/1ps
module sim_dpwm_dither_gen;
   localparam int N     = 12;
   localparam int M     = 2;
   localparam int FRAME = 1 << N;
   localparam int WIN   = 1 << M;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N+M-1:0] setpoint = '0;
   logic         pwm_out;
   logic         frame_start;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // Reference model state
   int m_pos  = 0;
   int m_duty = 0;
   int m_res  = 0;
   int fsum[WIN];

   always #2.5 clk = ~clk;

   dpwm_dither_gen #(.CNT_W(N), .FRAC_W(M)) u0 (
      .clk(clk), .rst(rst), .setpoint(setpoint),
      .pwm_out(pwm_out), .frame_start(frame_start)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: position in frame, duty of the frame, fraction residue
   always @(posedge clk) begin
      if (rst) begin
         m_pos = 0; m_duty = 0; m_res = 0;
      end else if (m_pos == FRAME - 1) begin
         m_res = m_res + int'(setpoint[M-1:0]);
         m_duty = int'(setpoint >> M);
         if (m_res >= WIN) begin
            m_res  = m_res - WIN;
            m_duty = m_duty + 1;
         end
         m_pos = 0;
      end else begin
         m_pos = m_pos + 1;
      end
   end

   // Per-clock comparison plus edge count per frame
   int  rises = 0, falls = 0;
   bit  prev_pwm = 1'b0;
   always @(negedge clk) begin
      if (!rst && !done) begin
         check(pwm_out == (m_pos < m_duty), "R5 pwm level", int'(pwm_out), int'(m_pos < m_duty));
         check(frame_start == (m_pos == 0), "R2 strobe", int'(frame_start), int'(m_pos == 0));
         if (m_pos == 0) begin rises = 0; falls = 0; end
         if (pwm_out && !prev_pwm) rises++;
         if (!pwm_out && prev_pwm) falls++;
         if (m_pos == FRAME - 1)
            check((rises <= 1) && (falls <= 1), "R7 edges per frame", rises * 10 + falls, 11);
      end
      prev_pwm = rst ? 1'b0 : pwm_out;
   end

   task automatic wait_start();
      do @(negedge clk); while (!frame_start);
   endtask

   // Measure WIN frames from a frame start; also check strobe spacing (R1)
   task automatic measure(output int total);
      int gap;
      total = 0;
      wait_start();
      for (int f = 0; f < WIN; f++) begin
         fsum[f] = 0;
         gap = 0;
         for (int c = 0; c < FRAME; c++) begin
            if (c != 0) @(negedge clk);
            fsum[f] += int'(pwm_out);
            gap++;
         end
         @(negedge clk);
         check(frame_start == 1'b1, "R1 frame length", gap, FRAME);
         total += fsum[f];
      end
   endtask

   initial begin
      int total, hi, nfull, nbig;
      setpoint = '1;
      repeat (3) @(negedge clk);
      check(pwm_out == 1'b0, "R9 reset output", int'(pwm_out), 0);
      check(frame_start == 1'b1, "R2 reset strobe", int'(frame_start), 1);
      rst = 1'b0;
      // R9: first frame is fully low even with a full-scale setpoint
      hi = 0;
      for (int c = 0; c < FRAME; c++) begin
         hi += int'(pwm_out);
         @(negedge clk);
      end
      check(hi == 0, "R9 first frame low", hi, 0);

      // Full scale: three of four frames saturate high (R6), total exact (R8)
      measure(total);
      check(total == int'(setpoint), "R8 window full scale", total, int'(setpoint));
      nfull = 0;
      for (int f = 0; f < WIN; f++) if (fsum[f] == FRAME) nfull++;
      check(nfull == 3, "R6 saturated frames", nfull, 3);

      // Zero: every frame fully low (R6)
      @(negedge clk); setpoint = '0;
      wait_start();
      measure(total);
      check(total == 0, "R6 zero window", total, 0);

      // Base 1000, fraction 1: one frame in four is one clock longer (R4)
      setpoint = N'(1000) * WIN + 1;
      wait_start();
      measure(total);
      check(total == 4001, "R8 window base1000 frac1", total, 4001);
      nbig = 0;
      for (int f = 0; f < WIN; f++) begin
         check(fsum[f] == 1000 || fsum[f] == 1001, "R4 two levels", fsum[f], 1000);
         if (fsum[f] == 1001) nbig++;
      end
      check(nbig == 1, "R4 carry count", nbig, 1);

      // Base 7, fraction 2
      setpoint = 7 * WIN + 2;
      wait_start();
      measure(total);
      check(total == 30, "R8 window base7 frac2", total, 30);

      // R3: change in mid-frame leaves the running frame alone
      wait_start();
      repeat (3) @(negedge clk);
      setpoint = '0;
      hi = 3;
      while (!frame_start) begin hi += int'(pwm_out); @(negedge clk); end
      check(hi >= 7, "R3 midframe change ignored", hi, 7);
      hi = 0;
      for (int c = 0; c < FRAME; c++) begin hi += int'(pwm_out); @(negedge clk); end
      check(hi == 0, "R3 change applied next frame", hi, 0);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule